// File: doc/BRIEF.md
# Memory protection controller register bank

This block is the configuration side of a memory protection controller that divides protected memory into fixed-size blocks. Every block has one bit in a lookup table. The table is stored as `NUM_WORDS` words of 32 bits. Software fills the table through a single window register. An index register chooses which word the window reaches. When auto-increment is on, the index steps by one after each full-word access to the window, so software can stream the whole table without writing the index again.

The bank decodes a 32-bit register space that accepts byte, halfword and word accesses. The register offsets are listed below; the decoder depends on them.

| Offset | Register |
|---|---|
| 0x00 | control |
| 0x10 | table size |
| 0x14 | block size code |
| 0x18 | index |
| 0x1C | window |
| 0x20 | interrupt status |
| 0x24 | clear |
| 0x28 | interrupt enable |
| 0x2C, 0x30 | two info words, which read zero |
| 0x34 | set |
| 0xFD0 to 0xFFC | twelve identification registers |

A lockdown bit in the control register write-protects the control, window and interrupt-enable registers until the next reset. The bank accepts a non-secure access only at the identification registers; at any lower offset it reads zero and changes nothing. The bank drives a level interrupt and presents the whole table on a flat bus for the gating logic.

Top module: `mpc_regbank`

## Requirements
- R1: After reset, control reads 0x00000100 and index reads 0. Interrupt status reads 0, interrupt enable reads 1, both info words (0x2C, 0x30) read 0, `irq` is 0 and every table word is 0.
- R2: Control keeps only bit 4 (secure response), bit 8 (auto-increment) and bit 31 (lockdown). Every other bit reads 0 and ignores writes.
- R3: A write to the index register (0x18) stores the written value modulo `NUM_WORDS`.
- R4: When auto-increment is set, a word-size read or write of the window (0x1C) advances the index by one, wrapping from `NUM_WORDS`-1 to 0. A byte or halfword access does not advance it, and no access advances it while auto-increment is clear.
- R5: While lockdown is set, writes to control, window and interrupt enable have no effect, and a blocked window write does not advance the index. Only reset clears lockdown.
- R6: A non-secure access (`bus_secure`=0) at an offset below 0xFD0 reads 0 and has no effect. A non-secure access can read the identification registers.
- R7: Writing 1 in bit 0 of the set register (0x34) sets interrupt status. Writing 1 in bit 0 of the clear register (0x24) clears it. `irq` is high exactly when status and enable are both 1.
- R8: `bus_size` encodes 0 as byte, 1 as halfword and 2 as word. A byte sits at lane `bus_addr[1:0]` and a halfword at lane `bus_addr[1]`. The written value is taken from the low bits of `bus_wdata`. A sub-word write to control, index or window is merged into the current word. A sub-word write to any other register is zero-extended. A sub-word read returns the addressed bytes right-aligned.
- R9: The table size register (0x10) reads `NUM_WORDS`. The block size code register (0x14) reads `BLK_LOG2`-5.
- R10: The identification registers read these bytes, starting at 0xFD0 and one per word: 04 00 00 00 60 B8 1B 00 0D F0 05 B1.
- R11: Reads of clear, set or unmapped offsets return 0. Writes to identification or unmapped offsets are ignored.
- R12: `lut_flat[32*i+31:32*i]` holds table word i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_rd | input | 1 | Read strobe; ignored when bus_wr is high |
| bus_wr | input | 1 | Write strobe |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_secure | input | 1 | 1 for a secure access |
| bus_wdata | input | 32 | Write value, low-aligned for sub-word accesses |
| bus_rdata | output | 32 | Read result, registered |
| irq | output | 1 | Level interrupt |
| lut_flat | output | 32*NUM_WORDS | Lookup table contents |

## Verification
The bank takes a write at the clock edge where `bus_wr` is sampled, so registers, `irq` and `lut_flat` show the new value straight after that edge. Read data is registered at the edge that samples `bus_rd` and stays until the next read. The index step caused by a window access lands at that same edge. Every access in the bench is applied at a falling edge and removed at the next falling edge. Results are sampled at that second falling edge, one rising edge after the stimulus.

// File: rtl/mpc_pkg.sv
package mpc_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFF_CTRL  = 12'h000;
  localparam logic [REG_AW-1:0] OFF_MAX   = 12'h010;
  localparam logic [REG_AW-1:0] OFF_CFG   = 12'h014;
  localparam logic [REG_AW-1:0] OFF_IDX   = 12'h018;
  localparam logic [REG_AW-1:0] OFF_WIN   = 12'h01C;
  localparam logic [REG_AW-1:0] OFF_STAT  = 12'h020;
  localparam logic [REG_AW-1:0] OFF_CLR   = 12'h024;
  localparam logic [REG_AW-1:0] OFF_EN    = 12'h028;
  localparam logic [REG_AW-1:0] OFF_SET   = 12'h034;
  localparam logic [REG_AW-1:0] OFF_ID_LO = 12'hFD0;
  localparam logic [REG_AW-1:0] OFF_ID_HI = 12'hFFC;

  localparam int B_SECRESP = 4;
  localparam int B_AUTOINC = 8;
  localparam int B_LOCK    = 31;
  localparam logic [31:0] CTRL_KEEP = 32'h8000_0110;
  localparam logic [31:0] CTRL_RST  = 32'h0000_0100;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} size_e;

  function automatic logic [7:0] id_byte(input logic [3:0] n);
    case (n)
      4'd4:    id_byte = 8'h60;
      4'd5:    id_byte = 8'hB8;
      4'd6:    id_byte = 8'h1B;
      4'd8:    id_byte = 8'h0D;
      4'd9:    id_byte = 8'hF0;
      4'd10:   id_byte = 8'h05;
      4'd11:   id_byte = 8'hB1;
      4'd0:    id_byte = 8'h04;
      default: id_byte = 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] merge_sub(input logic [31:0] old, input logic [31:0] wd,
                                            input logic [1:0] sz, input logic [1:0] lane);
    logic [31:0] r;
    r = old;
    case (sz)
      SZ_BYTE: r[{lane, 3'b000} +: 8] = wd[7:0];
      SZ_HALF: r[{lane[1], 4'b0000} +: 16] = wd[15:0];
      default: r = wd;
    endcase
    return r;
  endfunction

  function automatic logic [31:0] extract_sub(input logic [31:0] w, input logic [1:0] sz,
                                              input logic [1:0] lane);
    case (sz)
      SZ_BYTE: extract_sub = {24'h0, w[{lane, 3'b000} +: 8]};
      SZ_HALF: extract_sub = {16'h0, w[{lane[1], 4'b0000} +: 16]};
      default: extract_sub = w;
    endcase
  endfunction

  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned lim);
    return (cur + 1 >= lim) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/mpc_idx_ctr.sv
module mpc_idx_ctr #(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [31:0]      load_val,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx <= '0;
    else if (load)
      idx <= IDX_W'(load_val % 32'(NUM_WORDS));
    else if (step)
      idx <= IDX_W'(mpc_pkg::wrap_next(32'(idx), NUM_WORDS));
  end

  // R3: the index never leaves the table
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(idx) < NUM_WORDS);

  // R4: a step from the last word lands on word 0
  p_idx_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && 32'(idx) == NUM_WORDS - 1) |=> (idx == '0));
endmodule

// File: rtl/mpc_lut_store.sv
module mpc_lut_store #(
  parameter int NUM_WORDS = 4,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       sel,
  input  logic [31:0]            wdata,
  output logic [31:0]            cur_word,
  output logic [32*NUM_WORDS-1:0] lut_flat
);
  logic [31:0] mem [NUM_WORDS];

  for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (we && 32'(sel) == i)
        mem[i] <= wdata;
    end
    assign lut_flat[32*i +: 32] = mem[i];
  end

  always_comb begin
    cur_word = '0;
    for (int k = 0; k < NUM_WORDS; k++)
      if (32'(sel) == k) cur_word = mem[k];
  end

  // R12: a write lands in the selected word of the flat output
  p_lut_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(sel)] == $past(wdata)));
endmodule

// File: rtl/mpc_rd_mux.sv
module mpc_rd_mux #(
  parameter int NUM_WORDS = 4,
  parameter int BLK_LOG2  = 12,
  localparam int IDX_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1
) (
  input  logic [mpc_pkg::REG_AW-1:0] off,
  input  logic [31:0]                ctrl,
  input  logic [IDX_W-1:0]           idx,
  input  logic [31:0]                win_word,
  input  logic                       stat,
  input  logic                       en,
  output logic [31:0]                word
);
  import mpc_pkg::*;
  logic [REG_AW-1:0] id_off;
  assign id_off = off - OFF_ID_LO;

  always_comb begin
    case (off)
      OFF_CTRL: word = ctrl;
      OFF_MAX:  word = 32'(NUM_WORDS);
      OFF_CFG:  word = 32'(BLK_LOG2 - 5);
      OFF_IDX:  word = 32'(idx);
      OFF_WIN:  word = win_word;
      OFF_STAT: word = {31'h0, stat};
      OFF_EN:   word = {31'h0, en};
      default: begin
        if (off >= OFF_ID_LO && off <= OFF_ID_HI)
          word = {24'h0, id_byte(id_off[5:2])};
        else
          word = '0;
      end
    endcase
  end
endmodule

// File: rtl/mpc_regbank.sv
module mpc_regbank #(
  parameter int NUM_WORDS = 4,
  parameter int BLK_LOG2  = 12,
  localparam int IDX_W  = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
  localparam int LUT_W  = 32 * NUM_WORDS
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [mpc_pkg::REG_AW-1:0] bus_addr,
  input  logic                       bus_rd,
  input  logic                       bus_wr,
  input  logic [1:0]                 bus_size,
  input  logic                       bus_secure,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       irq,
  output logic [LUT_W-1:0]           lut_flat
);
  import mpc_pkg::*;

  logic [REG_AW-1:0] off;
  logic [1:0]        lane;
  logic              sec_ok, wr_ok, rd_ok, full_word, locked, autoinc;
  logic [31:0]       ctrl_q, win_word, old_word, merged, mux_word;
  logic              stat_q, en_q;
  logic [IDX_W-1:0]  idx;
  logic              ctrl_we, idx_load, win_we, win_rd, idx_step, en_we, set_hit, clr_hit;

  assign off       = {bus_addr[REG_AW-1:2], 2'b00};
  assign lane      = bus_addr[1:0];
  assign sec_ok    = bus_secure || (off >= OFF_ID_LO);
  assign wr_ok     = bus_wr && sec_ok;
  assign rd_ok     = bus_rd && !bus_wr && sec_ok;
  assign full_word = !(bus_size == SZ_BYTE || bus_size == SZ_HALF);
  assign locked    = ctrl_q[B_LOCK];
  assign autoinc   = ctrl_q[B_AUTOINC];

  always_comb begin
    case (off)
      OFF_CTRL: old_word = ctrl_q;
      OFF_IDX:  old_word = 32'(idx);
      OFF_WIN:  old_word = win_word;
      default:  old_word = '0;
    endcase
  end
  assign merged = merge_sub(old_word, bus_wdata, bus_size, lane);

  assign ctrl_we  = wr_ok && off == OFF_CTRL && !locked;
  assign idx_load = wr_ok && off == OFF_IDX;
  assign win_we   = wr_ok && off == OFF_WIN && !locked;
  assign win_rd   = rd_ok && off == OFF_WIN;
  assign idx_step = autoinc && full_word && (win_we || win_rd);
  assign en_we    = wr_ok && off == OFF_EN && !locked;
  assign set_hit  = wr_ok && off == OFF_SET && merged[0];
  assign clr_hit  = wr_ok && off == OFF_CLR && merged[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      stat_q <= 1'b0;
      en_q   <= 1'b1;
    end else begin
      if (ctrl_we) ctrl_q <= merged & CTRL_KEEP;
      if (en_we)   en_q   <= merged[0];
      if (clr_hit)      stat_q <= 1'b0;
      else if (set_hit) stat_q <= 1'b1;
    end
  end

  mpc_idx_ctr #(.NUM_WORDS(NUM_WORDS)) u_idx (
    .clk(clk), .rst_n(rst_n), .load(idx_load), .load_val(merged),
    .step(idx_step), .idx(idx)
  );

  mpc_lut_store #(.NUM_WORDS(NUM_WORDS)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(win_we), .sel(idx), .wdata(merged),
    .cur_word(win_word), .lut_flat(lut_flat)
  );

  mpc_rd_mux #(.NUM_WORDS(NUM_WORDS), .BLK_LOG2(BLK_LOG2)) u_mux (
    .off(off), .ctrl(ctrl_q), .idx(idx), .win_word(win_word),
    .stat(stat_q), .en(en_q), .word(mux_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd && !bus_wr)
      bus_rdata <= rd_ok ? extract_sub(mux_word, bus_size, lane) : 32'h0;
  end

  assign irq = stat_q & en_q;

  // R5: lockdown holds until reset
  p_lock_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked);

  // R5: a control write under lockdown leaves control untouched
  p_lock_ctrl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && bus_wr && off == OFF_CTRL) |=> $stable(ctrl_q));

  // R6: non-secure writes below the ID space change nothing
  p_ns_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_secure && off < OFF_ID_LO)
      |=> ($stable(ctrl_q) && $stable(en_q) && $stable(stat_q) && $stable(lut_flat)));

  // R6: non-secure reads below the ID space return zero
  p_ns_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && !bus_secure && off < OFF_ID_LO) |=> (bus_rdata == 32'h0));

  // R7: a set without clear raises the status
  p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_hit && !clr_hit) |=> stat_q);

  // R7: a clear drops the interrupt
  p_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !irq);
endmodule

// File: tb/tb_mpc_regbank.sv
module tb_mpc_regbank;
  localparam int NW   = 4;
  localparam int BL2  = 12;
  localparam int NV   = 62;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_secure = 1'b0;
  logic [1:0]  bus_size = 2'd2;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;
  logic [32*NW-1:0] lut_flat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  mpc_regbank #(.NUM_WORDS(NW), .BLK_LOG2(BL2)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_secure(bus_secure), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .lut_flat(lut_flat)
  );

  // vector: {req[3:0], is_wr, secure, size[1:0], addr[11:0], wdata[31:0], expect[31:0]}
  localparam bit W = 1'b1, R = 1'b0, S = 1'b1, N = 1'b0;
  localparam logic [1:0] B = 2'd0, H = 2'd1, D = 2'd2;
  localparam logic [83:0] VEC [NV] = '{
    {4'd1, R, S, D, 12'h000, 32'h0, 32'h0000_0100},  // R1 control reset
    {4'd1, R, S, D, 12'h018, 32'h0, 32'h0},          // R1 index reset
    {4'd1, R, S, D, 12'h028, 32'h0, 32'h1},          // R1 enable reset
    {4'd1, R, S, D, 12'h020, 32'h0, 32'h0},          // R1 status reset
    {4'd1, R, S, D, 12'h030, 32'h0, 32'h0},          // R1 info word
    {4'd9, R, S, D, 12'h010, 32'h0, 32'(NW)},        // R9 table size
    {4'd9, R, S, D, 12'h014, 32'h0, 32'(BL2-5)},     // R9 block code
    {4'd10, R, S, D, 12'hFD0, 32'h0, 32'h04},        // R10
    {4'd10, R, N, D, 12'hFE4, 32'h0, 32'hB8},        // R10 / R6 non-secure ID read
    {4'd10, R, N, D, 12'hFFC, 32'h0, 32'hB1},        // R10
    {4'd10, R, S, D, 12'hFF0, 32'h0, 32'h0D},        // R10
    {4'd2, W, S, D, 12'h000, 32'h7FFF_FFFF, 32'h0},
    {4'd2, R, S, D, 12'h000, 32'h0, 32'h0000_0110},  // R2 masked bits
    {4'd3, W, S, D, 12'h018, 32'd6, 32'h0},
    {4'd3, R, S, D, 12'h018, 32'h0, 32'd2},          // R3 modulo
    {4'd3, W, S, D, 12'h018, 32'd0, 32'h0},
    {4'd4, W, S, D, 12'h01C, 32'h1111_1111, 32'h0},
    {4'd4, R, S, D, 12'h018, 32'h0, 32'd1},          // R4 step on write
    {4'd4, W, S, D, 12'h01C, 32'h2222_2222, 32'h0},
    {4'd4, W, S, D, 12'h01C, 32'h3333_3333, 32'h0},
    {4'd4, W, S, D, 12'h01C, 32'h4444_4444, 32'h0},
    {4'd4, R, S, D, 12'h018, 32'h0, 32'd0},          // R4 wrap
    {4'd4, R, S, D, 12'h01C, 32'h0, 32'h1111_1111},  // R4 read steps
    {4'd4, R, S, D, 12'h01C, 32'h0, 32'h2222_2222},
    {4'd8, R, S, B, 12'h01D, 32'h0, 32'h33},         // R8 byte read
    {4'd4, R, S, D, 12'h018, 32'h0, 32'd2},          // R4 no step on byte
    {4'd8, W, S, H, 12'h01E, 32'h0000_ABCD, 32'h0},
    {4'd8, R, S, D, 12'h01C, 32'h0, 32'hABCD_3333},  // R8 merge
    {4'd8, W, S, B, 12'h029, 32'h01, 32'h0},
    {4'd8, R, S, D, 12'h028, 32'h0, 32'h0},          // R8 zero-extend
    {4'd7, W, S, D, 12'h028, 32'h1, 32'h0},
    {4'd7, W, S, D, 12'h034, 32'h1, 32'h0},
    {4'd7, R, S, D, 12'h020, 32'h0, 32'h1},          // R7 set
    {4'd8, W, S, B, 12'h025, 32'h01, 32'h0},
    {4'd8, R, S, D, 12'h020, 32'h0, 32'h1},          // R8 lane1 clear has no bit 0
    {4'd7, W, S, D, 12'h024, 32'h1, 32'h0},
    {4'd7, R, S, D, 12'h020, 32'h0, 32'h0},          // R7 clear
    {4'd11, R, S, D, 12'h024, 32'h0, 32'h0},         // R11 clear reads 0
    {4'd11, R, S, D, 12'h040, 32'h0, 32'h0},         // R11 unmapped
    {4'd11, W, S, D, 12'hFD0, 32'hFF, 32'h0},
    {4'd11, R, S, D, 12'hFD0, 32'h0, 32'h04},        // R11 ID write ignored
    {4'd6, W, N, D, 12'h000, 32'h0, 32'h0},
    {4'd6, R, S, D, 12'h000, 32'h0, 32'h0000_0110},  // R6 NS write no effect
    {4'd6, R, N, D, 12'h000, 32'h0, 32'h0},          // R6 NS read zero
    {4'd6, W, N, D, 12'h018, 32'd1, 32'h0},
    {4'd6, R, S, D, 12'h018, 32'h0, 32'd3},          // R6 index unchanged
    {4'd8, W, S, B, 12'h001, 32'h00, 32'h0},
    {4'd8, R, S, D, 12'h000, 32'h0, 32'h0000_0010},  // R8 control byte merge
    {4'd4, R, S, D, 12'h01C, 32'h0, 32'h4444_4444},
    {4'd4, R, S, D, 12'h018, 32'h0, 32'd3},          // R4 no step when off
    {4'd5, W, S, D, 12'h000, 32'h0000_0100, 32'h0},
    {4'd5, W, S, B, 12'h003, 32'h80, 32'h0},
    {4'd5, R, S, D, 12'h000, 32'h0, 32'h8000_0100},  // R5 lock set
    {4'd5, W, S, D, 12'h000, 32'h0, 32'h0},
    {4'd5, R, S, D, 12'h000, 32'h0, 32'h8000_0100},  // R5 control frozen
    {4'd5, W, S, D, 12'h028, 32'h0, 32'h0},
    {4'd5, R, S, D, 12'h028, 32'h0, 32'h1},          // R5 enable frozen
    {4'd5, W, S, D, 12'h018, 32'd0, 32'h0},
    {4'd5, W, S, D, 12'h01C, 32'hDEAD_BEEF, 32'h0},
    {4'd5, R, S, D, 12'h01C, 32'h0, 32'h1111_1111},  // R5 window frozen, no step
    {4'd4, R, S, D, 12'h018, 32'h0, 32'd1},          // R4 read still steps
    {4'd8, R, S, H, 12'h01E, 32'h0, 32'h2222}        // R8 halfword read
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit sec, input logic [1:0] sz,
                        input logic [11:0] a, input logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    bus_wr = wr; bus_rd = !wr; bus_secure = sec; bus_size = sz;
    bus_addr = a; bus_wdata = d;
    @(negedge clk);
    q = bus_rdata;
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    logic [31:0] q;
    do_reset();
    for (int i = 0; i < NV; i++) begin
      logic [83:0] v;
      v = VEC[i];
      access(v[79], v[78], v[77:76], v[75:64], v[63:32], q);
      if (!v[79]) check($sformatf("R%0d vec%0d", v[83:80], i), 128'(q), 128'(v[31:0]));
    end
    // R12 flat table view
    check("R12 lut_flat", 128'(lut_flat),
          {32'h4444_4444, 32'hABCD_3333, 32'h2222_2222, 32'h1111_1111});
    // R7 interrupt level under lockdown (enable stuck at 1)
    check("R7 irq idle", 128'(irq), 128'(0));
    access(W, S, D, 12'h034, 32'h1, q);
    check("R7 irq after set", 128'(irq), 128'(1));
    access(W, S, D, 12'h024, 32'h1, q);
    check("R7 irq after clear", 128'(irq), 128'(0));
    // R1 / R5 reset clears lockdown and the table
    do_reset();
    check("R1 irq after reset", 128'(irq), 128'(0));
    check("R1 table after reset", 128'(lut_flat), 128'(0));
    access(R, S, D, 12'h000, 32'h0, q);
    check("R5 lock cleared by reset", 128'(q), 128'(32'h0000_0100));
    // R7 masked interrupt
    access(W, S, D, 12'h028, 32'h0, q);
    access(W, S, D, 12'h034, 32'h1, q);
    check("R7 irq masked", 128'(irq), 128'(0));
    access(R, S, D, 12'h020, 32'h0, q);
    check("R7 status while masked", 128'(q), 128'(1));
    access(W, S, D, 12'h028, 32'h1, q);
    check("R7 irq unmasked", 128'(irq), 128'(1));
    finish_run();
  end

  initial begin
    #200000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule